// File: doc/BRIEF.md
# Up-Down PWM Generator with Event-Driven Action Qualifiers

This block produces two pulse-width-modulated outputs, A and B, from one shared time-base counter. The counter climbs from 0 to a programmed period value, then falls back to 0, and repeats. It advances only on ticks from a two-stage clock prescaler, and only while a global time-base enable is high. Instances that share that enable therefore begin counting on the same prescaled edge.

Each output has its own compare value. A compare value can be written through a shadow copy, which moves into the active copy when the counter reaches zero. In immediate mode a write lands in the active copy at once. On every tick, a small event table decides what the output does. The table holds one 2-bit action for each of four events: counter at zero, counter at period, compare match while rising, and compare match while falling. An optional phase-load path lets an external sync pulse preset the counter. With the phase-load enable off, the sync pulse is ignored.

Configuration arrives as single-cycle writes: an address, a data word and a write strobe.

Address map:

| Address | Register | Bit fields |
|---|---|---|
| 0 | Period | whole word |
| 1 | Prescaler | [2:0] high-speed code, [5:3] general code |
| 2 | Compare A | whole word |
| 3 | Compare B | whole word |
| 4 | Compare control | bit0 A immediate, bit1 B immediate, bit2 phase-load enable |
| 5 | Action table A | [1:0] zero, [3:2] period, [5:4] compare-up, [7:6] compare-down |
| 6 | Action table B | same layout as action table A |
| 7 | Phase value | whole word |

Top module: `updn_pwm_gen`

## Requirements
- R1: After reset the counter is 0, the direction flag shows counting up (dir_up_o=1), and pwm_a and pwm_b are 0.
- R2: With period P>0, each tick moves the counter one step through 0,1,...,P,P-1,...,0,1,... . At P the direction flag clears, so the next step is down. At 0 it sets again, so the next step is up. One full cycle is 2*P ticks.
- R3: A high-speed code h gives a divide of 1 when h=0 and 2*h otherwise. A general code g gives a divide of 2^g. While enabled, the counter advances once every (high-speed divide)*(general divide) clocks.
- R4: While tb_en is 0, the counter, the direction flag and the prescaler are held. After tb_en rises, the first counter step lands exactly one full divide of clocks later.
- R5: With the compare-control bit at 0 (shadow mode), a compare write goes to the shadow copy. The active copy takes the shadow value on the tick at which the counter is 0.
- R6: With the compare-control bit at 1 (immediate mode), a compare write replaces the active compare from the next clock.
- R7: Action codes are 0 = hold, 1 = drive low, 2 = drive high, 3 = toggle. The chosen action is applied on the tick edge at which its event holds, and outputs change on no other edge. With compare-up high and compare-down low, the output is high for 2*(P-C) ticks in each cycle.
- R8: A compare match is split by direction. It selects the compare-up action when the flag is set and the compare-down action when it is clear. Counter-at-zero and counter-at-period events select their own actions.
- R9: When several events hold on one tick, the one with the highest priority decides the action, even if that action is hold. The priority order, highest first, is compare match, then period, then zero.
- R10: With the phase-load enable at 0, sync_in has no effect. With it at 1, a sync_in pulse loads the phase value into the counter on the next clock.
- R11: The period register is 16 bits wide; a period of 1500 gives a cycle of 3000 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Global time-base enable |
| sync_in | input | 1 | External sync pulse for phase load |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | CNT_W (16) | Configuration write data |
| cnt_o | output | CNT_W (16) | Time-base counter value |
| dir_up_o | output | 1 | Direction flag, 1 = counting up |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 3-bit prescaler codes. With these codes, all 32 combinations of high-speed codes 0 to 7 and general codes 0 to 3 can be swept and timed against the product formula. Small periods of 3 to 10 ticks keep each cycle short. This brings every turnaround, compare-versus-zero and compare-versus-period collision, and shadow-load moment within reach in a few thousand clocks. A separate run at period 1500 confirms the full-width cycle length.

// File: rtl/updn_pwm_pkg.sv
package updn_pwm_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOW  = 2'd1,
      ACT_HIGH = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;

   // bit layout: [7:6] compare-down, [5:4] compare-up, [3:2] period, [1:0] zero
   typedef struct packed {
      act_e on_cmp_dn;
      act_e on_cmp_up;
      act_e on_prd;
      act_e on_zro;
   } aq_cfg_t;

   localparam logic [2:0] ADR_PRD   = 3'd0;
   localparam logic [2:0] ADR_PSC   = 3'd1;
   localparam logic [2:0] ADR_CMPA  = 3'd2;
   localparam logic [2:0] ADR_CMPB  = 3'd3;
   localparam logic [2:0] ADR_CCTL  = 3'd4;
   localparam logic [2:0] ADR_AQA   = 3'd5;
   localparam logic [2:0] ADR_AQB   = 3'd6;
   localparam logic [2:0] ADR_PHS   = 3'd7;

   function automatic logic act_apply(act_e a, logic cur);
      case (a)
         ACT_LOW:  return 1'b0;
         ACT_HIGH: return 1'b1;
         ACT_TGL:  return ~cur;
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/updn_pwm_prescale.sv
module updn_pwm_prescale #(
   parameter int HS_W   = 3,
   parameter int CK_W   = 3,
   parameter bit USE_HS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tb_en,
   input  logic [HS_W-1:0] hs_code,
   input  logic [CK_W-1:0] ck_code,
   output logic            tick
);
   localparam int HS_MAX  = (1 << HS_W) - 1;
   localparam int CK_MAX  = (1 << CK_W) - 1;
   localparam int DIV_MAX = 2 * HS_MAX * (1 << CK_MAX);
   localparam int PS_W    = $clog2(DIV_MAX + 1);

   logic [PS_W-1:0] hs_div;
   logic [PS_W-1:0] ck_div;
   logic [PS_W-1:0] div;
   logic [PS_W-1:0] pcnt;

   generate
      if (USE_HS) begin : g_hs
         assign hs_div = (hs_code == '0) ? PS_W'(1) : PS_W'({hs_code, 1'b0});
      end else begin : g_no_hs
         logic unused_hs;
         assign unused_hs = ^hs_code;
         assign hs_div    = PS_W'(1);
      end
   endgenerate

   assign ck_div = PS_W'(1) << ck_code;
   assign div    = hs_div * ck_div;
   assign tick   = tb_en && (pcnt >= (div - PS_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n)      pcnt <= '0;
      else if (!tb_en) pcnt <= '0;
      else if (tick)   pcnt <= '0;
      else             pcnt <= pcnt + PS_W'(1);
   end

endmodule

// File: rtl/updn_pwm_timebase.sv
module updn_pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] prd,
   input  logic             sync_ld,
   input  logic [CNT_W-1:0] phase,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (sync_ld) begin
         cnt <= phase;
      end else if (tick) begin
         if (prd == '0) begin
            cnt    <= '0;
            dir_up <= 1'b1;
         end else if (dir_up) begin
            if (cnt >= prd) begin
               dir_up <= 1'b0;
               cnt    <= cnt - 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            if (cnt == '0) begin
               dir_up <= 1'b1;
               cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/updn_pwm_cmp.sv
module updn_pwm_cmp #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             imm,
   input  logic [CNT_W-1:0] wdata,
   input  logic             zero_tick,
   output logic [CNT_W-1:0] active
);
   logic [CNT_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
      end else begin
         if (wr && imm)
            active <= wdata;
         else if (zero_tick && !imm)
            active <= shadow;
         if (wr && !imm)
            shadow <= wdata;
      end
   end

endmodule

// File: rtl/updn_pwm_aq.sv
module updn_pwm_aq
   import updn_pwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic             dir_up,
   input  logic [CNT_W-1:0] prd,
   input  logic [CNT_W-1:0] cmp,
   input  aq_cfg_t          cfg,
   output logic             out
);
   act_e sel;

   always_comb begin
      if (cnt == cmp)
         sel = dir_up ? cfg.on_cmp_up : cfg.on_cmp_dn;
      else if (cnt == prd)
         sel = cfg.on_prd;
      else if (cnt == '0)
         sel = cfg.on_zro;
      else
         sel = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    out <= 1'b0;
      else if (tick) out <= act_apply(sel, out);
   end

endmodule

// File: rtl/updn_pwm_gen.sv
module updn_pwm_gen
   import updn_pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int HS_W   = 3,
   parameter int CK_W   = 3,
   parameter bit USE_HS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_en,
   input  logic             sync_in,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_up_o,
   output logic             pwm_a,
   output logic             pwm_b
);
   localparam int NCH   = 2;
   localparam int AQ_W  = $bits(aq_cfg_t);
   localparam int PSC_W = HS_W + CK_W;

   generate
      if (CNT_W < AQ_W) begin : g_bad_cnt_w
         $error("CNT_W must hold an action table word");
      end
      if (PSC_W > CNT_W) begin : g_bad_psc_w
         $error("prescaler codes must fit in one write word");
      end
      if (CK_W > 4) begin : g_bad_ck_w
         $error("CK_W above 4 is not supported");
      end
   endgenerate

   logic [CNT_W-1:0] prd_q;
   logic [CNT_W-1:0] phase_q;
   logic [HS_W-1:0]  hs_q;
   logic [CK_W-1:0]  ck_q;
   logic [NCH-1:0]   imm_q;
   logic             phase_en_q;
   aq_cfg_t          aq_q [NCH];

   logic             tick_w;
   logic             sync_ld;
   logic             zero_tick;
   logic [CNT_W-1:0] cnt_w;
   logic             dir_w;
   logic [NCH-1:0]   pwm_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd_q      <= '0;
         phase_q    <= '0;
         hs_q       <= '0;
         ck_q       <= '0;
         imm_q      <= '0;
         phase_en_q <= 1'b0;
         aq_q[0]    <= '0;
         aq_q[1]    <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_PRD:  prd_q   <= wr_data;
            ADR_PHS:  phase_q <= wr_data;
            ADR_PSC: begin
               hs_q <= wr_data[HS_W-1:0];
               ck_q <= wr_data[PSC_W-1:HS_W];
            end
            ADR_CCTL: begin
               imm_q      <= wr_data[NCH-1:0];
               phase_en_q <= wr_data[NCH];
            end
            ADR_AQA:  aq_q[0] <= aq_cfg_t'(wr_data[AQ_W-1:0]);
            ADR_AQB:  aq_q[1] <= aq_cfg_t'(wr_data[AQ_W-1:0]);
            default: ;
         endcase
      end
   end

   assign sync_ld   = sync_in && phase_en_q;
   assign zero_tick = tick_w && (cnt_w == '0);

   updn_pwm_prescale #(
      .HS_W  (HS_W),
      .CK_W  (CK_W),
      .USE_HS(USE_HS)
   ) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tb_en  (tb_en),
      .hs_code(hs_q),
      .ck_code(ck_q),
      .tick   (tick_w)
   );

   updn_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_w),
      .prd    (prd_q),
      .sync_ld(sync_ld),
      .phase  (phase_q),
      .cnt    (cnt_w),
      .dir_up (dir_w)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         logic [CNT_W-1:0] act_cmp;
         logic             cmp_wr;

         assign cmp_wr = wr_en && (wr_addr == ((ch == 0) ? ADR_CMPA : ADR_CMPB));

         updn_pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (cmp_wr),
            .imm      (imm_q[ch]),
            .wdata    (wr_data),
            .zero_tick(zero_tick),
            .active   (act_cmp)
         );

         updn_pwm_aq #(.CNT_W(CNT_W)) u_aq (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_w),
            .cnt   (cnt_w),
            .dir_up(dir_w),
            .prd   (prd_q),
            .cmp   (act_cmp),
            .cfg   (aq_q[ch]),
            .out   (pwm_w[ch])
         );
      end
   endgenerate

   assign cnt_o    = cnt_w;
   assign dir_up_o = dir_w;
   assign pwm_a    = pwm_w[0];
   assign pwm_b    = pwm_w[1];

endmodule

// File: rtl/updn_pwm_chk.sv
module updn_pwm_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             sync_in,
   input logic             phase_en,
   input logic [CNT_W-1:0] phase,
   input logic [CNT_W-1:0] prd,
   input logic [CNT_W-1:0] cnt,
   input logic             dir_up,
   input logic             pwm_a,
   input logic             pwm_b
);
   logic sld;
   assign sld = sync_in && phase_en;

   AST_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sld && dir_up && prd != '0 && cnt >= prd) |=> !dir_up); // R2

   AST_TURN_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sld && !dir_up && prd != '0 && cnt == '0) |=> (dir_up && cnt == CNT_W'(1))); // R2

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sld && prd != '0) |=>
         ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == CNT_W'($past(cnt) - 1'b1)))); // R2

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !sld) |=> ($stable(cnt) && $stable(dir_up))); // R4

   AST_OUT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(pwm_a) && $stable(pwm_b))); // R7

   AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sld |=> (cnt == $past(phase))); // R10

   AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in && !phase_en && !tick) |=> $stable(cnt)); // R10

endmodule

bind updn_pwm_gen updn_pwm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_w),
   .sync_in (sync_in),
   .phase_en(phase_en_q),
   .phase   (phase_q),
   .prd     (prd_q),
   .cnt     (cnt_w),
   .dir_up  (dir_w),
   .pwm_a   (pwm_a),
   .pwm_b   (pwm_b)
);

// File: tb/updn_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module updn_pwm_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tb_en = 1'b0;
   logic        sync_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cnt_o;
   logic        dir_up_o, pwm_a, pwm_b;

   always #2 clk = ~clk;

   updn_pwm_gen dut_i (
      .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_o(cnt_o), .dir_up_o(dir_up_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   int errs = 0;
   int checks = 0;
   bit mchk = 1'b0;
   bit done = 1'b0;
   string tag = "R1";

   task automatic check(bit ok, string req, int act, int exp, string what);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural expectation, written from the requirements
   int m_cnt, m_pcnt, m_prd, m_ph, m_hs, m_ck;
   bit m_dir, m_a, m_b, m_phen;
   bit [1:0] m_imm;
   int m_sh [2];
   int m_ac [2];
   bit [7:0] m_aq [2];
   int n_cnt, n_pcnt, dv, nac0, nac1, nsh0, nsh1;
   bit tk, n_dir, n_a, n_b;

   function automatic int pick(bit [7:0] cfg, int cmp, int c, bit up, int p);
      if (c == cmp) return up ? int'(cfg[5:4]) : int'(cfg[7:6]);
      if (c == p)   return int'(cfg[3:2]);
      if (c == 0)   return int'(cfg[1:0]);
      return 0;
   endfunction

   function automatic bit apply(int a, bit cur);
      case (a)
         1: return 1'b0;
         2: return 1'b1;
         3: return ~cur;
         default: return cur;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_dir = 1; m_pcnt = 0; m_a = 0; m_b = 0;
         m_prd = 0; m_ph = 0; m_hs = 0; m_ck = 0; m_imm = 0; m_phen = 0;
         m_sh[0] = 0; m_sh[1] = 0; m_ac[0] = 0; m_ac[1] = 0;
         m_aq[0] = 0; m_aq[1] = 0;
      end else begin
         dv = ((m_hs == 0) ? 1 : 2 * m_hs) * (1 << m_ck);
         tk = tb_en && (m_pcnt >= dv - 1);
         n_a = tk ? apply(pick(m_aq[0], m_ac[0], m_cnt, m_dir, m_prd), m_a) : m_a;
         n_b = tk ? apply(pick(m_aq[1], m_ac[1], m_cnt, m_dir, m_prd), m_b) : m_b;
         n_cnt = m_cnt; n_dir = m_dir;
         if (sync_in && m_phen) n_cnt = m_ph;
         else if (tk) begin
            if (m_prd == 0) begin n_cnt = 0; n_dir = 1; end
            else if (m_dir) begin
               if (m_cnt >= m_prd) begin n_dir = 0; n_cnt = m_cnt - 1; end
               else n_cnt = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin n_dir = 1; n_cnt = 1; end
               else n_cnt = m_cnt - 1;
            end
         end
         n_pcnt = (!tb_en || tk) ? 0 : m_pcnt + 1;
         nac0 = m_ac[0]; nac1 = m_ac[1]; nsh0 = m_sh[0]; nsh1 = m_sh[1];
         if (wr_en && wr_addr == 2 && m_imm[0]) nac0 = int'(wr_data);
         else if (tk && m_cnt == 0 && !m_imm[0]) nac0 = m_sh[0];
         if (wr_en && wr_addr == 2 && !m_imm[0]) nsh0 = int'(wr_data);
         if (wr_en && wr_addr == 3 && m_imm[1]) nac1 = int'(wr_data);
         else if (tk && m_cnt == 0 && !m_imm[1]) nac1 = m_sh[1];
         if (wr_en && wr_addr == 3 && !m_imm[1]) nsh1 = int'(wr_data);
         if (wr_en) begin
            case (wr_addr)
               0: m_prd = int'(wr_data);
               1: begin m_hs = int'(wr_data[2:0]); m_ck = int'(wr_data[5:3]); end
               4: begin m_imm = wr_data[1:0]; m_phen = wr_data[2]; end
               5: m_aq[0] = wr_data[7:0];
               6: m_aq[1] = wr_data[7:0];
               7: m_ph = int'(wr_data);
               default: ;
            endcase
         end
         m_cnt = n_cnt; m_dir = n_dir; m_pcnt = n_pcnt; m_a = n_a; m_b = n_b;
         m_ac[0] = nac0; m_ac[1] = nac1; m_sh[0] = nsh0; m_sh[1] = nsh1;
      end
   end

   always @(negedge clk) begin
      if (mchk && !done) begin
         check(int'(cnt_o) == m_cnt, "R2", int'(cnt_o), m_cnt, {"counter during ", tag});
         check(dir_up_o == m_dir, "R2", int'(dir_up_o), int'(m_dir), {"direction during ", tag});
         check(pwm_a == m_a, "R7", int'(pwm_a), int'(m_a), {"pwm_a during ", tag});
         check(pwm_b == m_b, "R7", int'(pwm_b), int'(m_b), {"pwm_b during ", tag});
      end
   end

   // ---------------- stimulus helpers (called at a falling edge)
   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_at(input int v, input bit up);
      while (!(int'(cnt_o) == v && dir_up_o == up)) @(negedge clk);
   endtask

   task automatic cycles_to_change(output int n);
      logic [15:0] c0;
      c0 = cnt_o;
      n = 0;
      do begin @(negedge clk); n++; end while (cnt_o == c0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errs++; checks++;
         $display("FAIL watchdog: actual=0 expected=1 (run did not complete)");
         summary();
         $finish;
      end
   end

   initial begin
      int n, hi;
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cnt_o == 0, "R1", int'(cnt_o), 0, "counter after reset");
      check(dir_up_o == 1'b1, "R1", int'(dir_up_o), 1, "direction after reset");
      check(pwm_a == 1'b0, "R1", int'(pwm_a), 0, "pwm_a after reset");
      check(pwm_b == 1'b0, "R1", int'(pwm_b), 0, "pwm_b after reset");
      mchk = 1'b1;

      // R8: mixed event tables, small period
      tag = "R8";
      wr(0, 5); wr(1, 0); wr(5, 'h60); wr(6, 'h93); wr(2, 2); wr(3, 4);
      tb_en = 1'b1;
      repeat (60) @(negedge clk);

      // R3: prescaler sweep, divide = hsdiv * 2^ck
      tag = "R3";
      wr(0, 3);
      for (int h = 0; h < 8; h++) begin
         for (int g = 0; g < 4; g++) begin
            int exp_div;
            exp_div = ((h == 0) ? 1 : 2 * h) * (1 << g);
            wr(1, (g << 3) | h);
            cycles_to_change(n);
            cycles_to_change(n);
            check(n == exp_div, "R3", n, exp_div, $sformatf("step spacing hs=%0d ck=%0d", h, g));
         end
      end

      // R4: hold while disabled, aligned start after enable
      tag = "R4";
      wr(1, 0);
      tb_en = 1'b0;
      held = cnt_o;
      repeat (20) @(negedge clk);
      check(cnt_o == held, "R4", int'(cnt_o), int'(held), "counter held while disabled");
      wr(1, (1 << 3) | 2);
      tb_en = 1'b1;
      cycles_to_change(n);
      check(n == 8, "R4", n, 8, "first step after enable");

      // R5/R7: shadow compare and duty
      tag = "R5";
      wr(1, 0); wr(0, 10); wr(4, 0); wr(5, 'h60); wr(2, 4);
      repeat (60) @(negedge clk);
      wait_at(0, 1'b0);
      hi = 0;
      for (int k = 0; k < 20; k++) begin
         if (pwm_a) hi++;
         @(negedge clk);
      end
      check(hi == 12, "R7", hi, 12, "pwm_a high ticks per cycle P=10 C=4");
      wait_at(2, 1'b1);
      wr(2, 7);
      wait_at(6, 1'b1);
      check(pwm_a == 1'b1, "R5", int'(pwm_a), 1, "old active compare kept until zero");
      wait_at(0, 1'b0);
      wait_at(6, 1'b1);
      check(pwm_a == 1'b0, "R5", int'(pwm_a), 0, "shadow value active after zero");

      // R6: immediate compare write
      tag = "R6";
      wr(4, 1);
      wait_at(2, 1'b1);
      wr(2, 3);
      wait_at(4, 1'b1);
      check(pwm_a == 1'b1, "R6", int'(pwm_a), 1, "immediate compare used at once");

      // R9: priority of compare over period and zero
      tag = "R9";
      wr(0, 6); wr(4, 3); wr(2, 6); wr(5, 'h64); wr(3, 0); wr(6, 'h89);
      repeat (30) @(negedge clk);
      wait_at(6, 1'b1);
      @(negedge clk);
      check(pwm_a == 1'b1, "R9", int'(pwm_a), 1, "compare-up beats period");
      wait_at(1, 1'b1);
      check(pwm_b == 1'b1, "R9", int'(pwm_b), 1, "compare-down beats zero");

      // R10: sync ignored, then phase load
      tag = "R10";
      wr(7, 3);
      wait_at(1, 1'b1);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      check(cnt_o == 2, "R10", int'(cnt_o), 2, "sync ignored with phase load off");
      wr(4, 7);
      wait_at(5, 1'b1);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      check(cnt_o == 3, "R10", int'(cnt_o), 3, "phase value loaded on sync");

      // R11: full-width period
      tag = "R11";
      wr(4, 0); wr(0, 1500);
      while (cnt_o != 0) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (cnt_o != 0);
      check(n == 3000, "R11", n, 3000, "cycle length at period 1500");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule